// File: doc/BRIEF.md
# Privilege-Aware Special Register File

This block holds the mode-dependent special state of a processor core. It keeps two banked stack pointers (main and process), a priority mask, a three-bit control register and a coprocessor access register that holds two separate two-bit floating-point access fields. The core's decode stage issues single-cycle read or write requests through a register select. The block takes the current execution mode as an input and applies the privilege rules to every request. Reads that privilege forbids return zero. Writes that privilege forbids are dropped. Thread code can lower its own privilege but cannot raise it again.

From the stored state the block derives two outputs: which stack pointer is active and whether execution is privileged. It also checks each floating-point instruction that the core reports. An allowed instruction can set the floating-point-context-active flag in the control register. A forbidden one produces a one-cycle usage-fault pulse on the next cycle.

Top module: `psr_file`

## Requirements
- R1: While `in_handler` is 1, `privileged` is 1 and `use_psp` is 0, whatever the control register holds.
- R2: While `in_handler` is 0, `privileged` is the inverse of control bit 0 (unprivileged flag), and `use_psp` equals control bit 1 (process stack select).
- R3: A read (`req_valid`=1, `req_write`=0) returns the selected register on `rd_data` in the same cycle. The selects are: 0 main stack pointer, 1 process stack pointer, 2 priority mask, 3 control, 4 coprocessor access. Selects 5 to 7, and cycles with no read, give zero.
- R4: Without privilege, reads of selects 0, 1 and 2 return zero. Control and coprocessor access stay readable.
- R5: A write made without privilege changes no register.
- R6: A privileged write updates the selected register from the next cycle. Only the low MASK_W bits of the mask are kept. Only control bits 2:0 are kept (bit 2 is the floating-point-context-active flag). Only coprocessor bits 3:0 are kept, with field A in bits 1:0 and field B in bits 3:2. All other bits read as zero.
- R7: Once thread code is unprivileged, it stays unprivileged until a handler-mode write clears control bit 0.
- R8: After reset, every register is zero. The core is therefore privileged, uses the main stack, and both floating-point access fields are disabled.
- R9: A floating-point instruction (`fp_exec`=1) is allowed only if fields A and B are equal and either both are 11, or both are 01 while privileged. Codes 00 and 10 deny every access. Each denied cycle produces `fp_fault`=1 for exactly the following cycle.
- R10: An allowed floating-point instruction while `fp_auto_en`=1 sets control bit 2 from the next cycle. This takes precedence over a control write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_sel | input | 3 | Register select |
| req_wdata | input | DATA_W | Write data |
| in_handler | input | 1 | 1 handler mode, 0 thread mode |
| fp_exec | input | 1 | A floating-point instruction executes this cycle |
| fp_auto_en | input | 1 | Enables automatic setting of the context-active flag |
| rd_data | output | DATA_W | Read data |
| use_psp | output | 1 | Process stack pointer active |
| privileged | output | 1 | Effective privilege |
| fp_fault | output | 1 | Usage-fault pulse for a denied floating-point access |

## Verification
The assertions assume that `in_handler`, `fp_exec` and the request inputs change only between clock edges and stay low while reset is asserted. The one-way privilege property also assumes the mode input is the only route back to handler level. The bench drives every input at the falling edge and holds all of them at zero through reset and through the two-cycle reset release. Its random mix of modes, selects and data covers unprivileged phases, handler recoveries, matching and mismatched access fields, and the reserved code.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [2:0] {
    SEL_MSP  = 3'd0,
    SEL_PSP  = 3'd1,
    SEL_MASK = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_CPAC = 3'd4
  } sreg_sel_e;

  typedef enum logic [1:0] {
    FPA_OFF  = 2'b00,
    FPA_PRIV = 2'b01,
    FPA_RSVD = 2'b10,
    FPA_FULL = 2'b11
  } fp_acc_e;

  typedef struct packed {
    logic fpca;
    logic spsel;
    logic unpriv;
  } ctrl_t;

  localparam int CTRL_W = 3;
  localparam int CPAC_W = 4;
endpackage

// File: rtl/psr_priv_gate.sv
module psr_priv_gate (
  input  logic in_handler,
  input  logic unpriv_bit,
  input  logic spsel_bit,
  input  logic req_valid,
  input  logic req_write,
  output logic privileged,
  output logic use_psp,
  output logic wr_ok
);
  always_comb begin
    privileged = in_handler | ~unpriv_bit;
    use_psp    = ~in_handler & spsel_bit;
    wr_ok      = req_valid & req_write & privileged;
  end
endmodule

// File: rtl/psr_fp_check.sv
module psr_fp_check
  import psr_pkg::*;
(
  input  logic [1:0] fld_a,
  input  logic [1:0] fld_b,
  input  logic       privileged,
  input  logic       fp_exec,
  output logic       fp_ok,
  output logic       fp_bad
);
  logic allow;
  always_comb begin
    allow = 1'b0;
    if (fld_a == fld_b) begin
      case (fp_acc_e'(fld_a))
        FPA_FULL: allow = 1'b1;
        FPA_PRIV: allow = privileged;
        default:  allow = 1'b0;
      endcase
    end
    fp_ok  = fp_exec & allow;
    fp_bad = fp_exec & ~allow;
  end
endmodule

// File: rtl/psr_rd_mux.sv
module psr_rd_mux
  import psr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MASK_W = 8
) (
  input  logic [2:0]        sel,
  input  logic              rd_en,
  input  logic              privileged,
  input  logic [DATA_W-1:0] msp,
  input  logic [DATA_W-1:0] psp,
  input  logic [MASK_W-1:0] mask,
  input  ctrl_t             ctrl,
  input  logic [CPAC_W-1:0] cpac,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (sel)
        SEL_MSP:  if (privileged) rd_data = msp;
        SEL_PSP:  if (privileged) rd_data = psp;
        SEL_MASK: if (privileged) rd_data[MASK_W-1:0] = mask;
        SEL_CTRL: rd_data[CTRL_W-1:0] = ctrl;
        SEL_CPAC: rd_data[CPAC_W-1:0] = cpac;
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/psr_file.sv
module psr_file
  import psr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              in_handler,
  input  logic              fp_exec,
  input  logic              fp_auto_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              use_psp,
  output logic              privileged,
  output logic              fp_fault
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [DATA_W-1:0] msp_q, msp_d, psp_q, psp_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic [CPAC_W-1:0] cpac_q, cpac_d;
  logic              fault_q;
  logic              wr_ok, fp_ok, fp_bad;

  psr_priv_gate u_gate (
    .in_handler (in_handler),
    .unpriv_bit (ctrl_q.unpriv),
    .spsel_bit  (ctrl_q.spsel),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .privileged (privileged),
    .use_psp    (use_psp),
    .wr_ok      (wr_ok)
  );

  psr_fp_check u_fp (
    .fld_a      (cpac_q[1:0]),
    .fld_b      (cpac_q[3:2]),
    .privileged (privileged),
    .fp_exec    (fp_exec),
    .fp_ok      (fp_ok),
    .fp_bad     (fp_bad)
  );

  psr_rd_mux #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_rd (
    .sel        (req_sel),
    .rd_en      (req_valid & ~req_write),
    .privileged (privileged),
    .msp        (msp_q),
    .psp        (psp_q),
    .mask       (mask_q),
    .ctrl       (ctrl_q),
    .cpac       (cpac_q),
    .rd_data    (rd_data)
  );

  always_comb begin
    msp_d  = msp_q;
    psp_d  = psp_q;
    mask_d = mask_q;
    ctrl_d = ctrl_q;
    cpac_d = cpac_q;
    if (wr_ok) begin
      case (req_sel)
        SEL_MSP:  msp_d  = req_wdata;
        SEL_PSP:  psp_d  = req_wdata;
        SEL_MASK: mask_d = req_wdata[MASK_W-1:0];
        SEL_CTRL: ctrl_d = ctrl_t'(req_wdata[CTRL_W-1:0]);
        SEL_CPAC: cpac_d = req_wdata[CPAC_W-1:0];
        default:  ;
      endcase
    end
    if (fp_ok && fp_auto_en) ctrl_d.fpca = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      msp_q   <= '0;
      psp_q   <= '0;
      mask_q  <= '0;
      ctrl_q  <= '0;
      cpac_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        msp_q  <= msp_d;
        psp_q  <= psp_d;
        mask_q <= mask_d;
        cpac_q <= cpac_d;
      end
      if (wr_ok || fp_ok) ctrl_q <= ctrl_d;
      fault_q <= fp_bad;
    end
  end

  assign fp_fault = fault_q;
endmodule

// File: rtl/psr_file_chk.sv
module psr_file_chk
  import psr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MASK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [2:0]        req_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              in_handler,
  input logic              privileged,
  input logic              use_psp,
  input logic              fp_exec,
  input logic              fp_fault,
  input logic [DATA_W-1:0] msp_q,
  input logic [DATA_W-1:0] psp_q,
  input logic [MASK_W-1:0] mask_q,
  input logic [CPAC_W-1:0] cpac_q
);
  // R1
  handler_priv_msp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler |-> (privileged && !use_psp));

  // R4
  unpriv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !privileged && (req_sel <= 3'd2)) |-> (rd_data == '0));

  // R5
  unpriv_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !privileged) |=>
      ($stable(msp_q) && $stable(psp_q) && $stable(mask_q) && $stable(cpac_q)));

  // R7
  priv_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !privileged |=> (in_handler || !privileged));

  // R9
  fault_follows_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_fault |-> $past(fp_exec));
endmodule

bind psr_file psr_file_chk #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_sel    (req_sel),
  .rd_data    (rd_data),
  .in_handler (in_handler),
  .privileged (privileged),
  .use_psp    (use_psp),
  .fp_exec    (fp_exec),
  .fp_fault   (fp_fault),
  .msp_q      (msp_q),
  .psp_q      (psp_q),
  .mask_q     (mask_q),
  .cpac_q     (cpac_q)
);

// File: tb/psr_file_test.sv
module psr_file_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int MASK_W = 8;
  localparam int N_RANDOM = 4000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write, in_handler, fp_exec, fp_auto_en;
  logic [2:0]        req_sel;
  logic [DATA_W-1:0] req_wdata;
  logic [DATA_W-1:0] rd_data;
  logic              use_psp, privileged, fp_fault;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [DATA_W-1:0] m_msp, m_psp;
  logic [MASK_W-1:0] m_mask;
  logic [2:0]        m_ctrl;
  logic [3:0]        m_cpac;
  logic              m_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_file #(.DATA_W(DATA_W), .MASK_W(MASK_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata), .in_handler(in_handler),
    .fp_exec(fp_exec), .fp_auto_en(fp_auto_en), .rd_data(rd_data),
    .use_psp(use_psp), .privileged(privileged), .fp_fault(fp_fault)
  );

  function automatic logic exp_priv(input logic h);
    return h | ~m_ctrl[0];
  endfunction

  function automatic logic fp_allowed(input logic pv);
    if (m_cpac[1:0] != m_cpac[3:2]) return 1'b0;
    if (m_cpac[1:0] == 2'b11) return 1'b1;
    if (m_cpac[1:0] == 2'b01) return pv;
    return 1'b0;
  endfunction

  function automatic logic [DATA_W-1:0] exp_read(input logic [2:0] s, input logic pv);
    logic [DATA_W-1:0] r;
    r = '0;
    case (s)
      3'd0: if (pv) r = m_msp;
      3'd1: if (pv) r = m_psp;
      3'd2: if (pv) r[MASK_W-1:0] = m_mask;
      3'd3: r[2:0] = m_ctrl;
      3'd4: r[3:0] = m_cpac;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [2:0] s,
                      input logic [DATA_W-1:0] d, input logic h,
                      input logic fx, input logic au);
    logic pv;
    logic nfault;
    @(negedge clk);
    req_valid = v; req_write = w; req_sel = s; req_wdata = d;
    in_handler = h; fp_exec = fx; fp_auto_en = au;
    #1;
    pv = exp_priv(h);
    chk(h ? "R1 privileged" : "R2 privileged", {{(DATA_W-1){1'b0}}, privileged}, {{(DATA_W-1){1'b0}}, pv});
    chk(h ? "R1 use_psp" : "R2 use_psp", {{(DATA_W-1){1'b0}}, use_psp}, {{(DATA_W-1){1'b0}}, ~h & m_ctrl[1]});
    chk("R9 fp_fault", {{(DATA_W-1){1'b0}}, fp_fault}, {{(DATA_W-1){1'b0}}, m_fault});
    if (v && !w) begin
      if (s > 3'd4)            chk("R3 read unimplemented", rd_data, exp_read(s, pv));
      else if (!pv && s < 3'd3) chk("R4 unprivileged read", rd_data, exp_read(s, pv));
      else                      chk("R6 read value", rd_data, exp_read(s, pv));
    end else begin
      chk("R3 idle read", rd_data, '0);
    end
    @(posedge clk);
    nfault = fx & ~fp_allowed(pv);
    if (v && w && pv) begin
      case (s)
        3'd0: m_msp  = d;
        3'd1: m_psp  = d;
        3'd2: m_mask = d[MASK_W-1:0];
        3'd3: m_ctrl = d[2:0];
        3'd4: m_cpac = d[3:0];
        default: ;
      endcase
    end
    if (fx && au && fp_allowed(pv)) m_ctrl[2] = 1'b1;
    m_fault = nfault;
  endtask

  task automatic rd(input logic [2:0] s, input logic h);
    step(1'b1, 1'b0, s, '0, h, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_sel = '0; req_wdata = '0;
    in_handler = 0; fp_exec = 0; fp_auto_en = 0;
    m_msp = '0; m_psp = '0; m_mask = '0; m_ctrl = '0; m_cpac = '0; m_fault = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R8: reset values, privileged thread on main stack, FP disabled
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      req_valid = 1; req_write = 0; req_sel = 3'(i);
      #1;
      chk("R8 reset value", rd_data, '0);
    end
    chk("R8 reset privileged", {{(DATA_W-1){1'b0}}, privileged}, {{(DATA_W-1){1'b0}}, 1'b1});
    chk("R8 reset stack", {{(DATA_W-1){1'b0}}, use_psp}, '0);
    step(0, 0, 0, '0, 0, 1, 1);        // R8: disabled access faults
    step(0, 0, 0, '0, 0, 0, 0);

    // R6: privileged writes, only implemented bits kept
    step(1, 1, 3'd0, 32'hDEAD_BEEF, 0, 0, 0);
    step(1, 1, 3'd2, 32'hFFFF_FFA5, 0, 0, 0);
    step(1, 1, 3'd3, 32'hFFFF_FFF2, 0, 0, 0);
    rd(3'd3, 0); rd(3'd2, 0); rd(3'd0, 0);

    // R2 / R5 / R7: drop privilege, then ignored writes, then handler recovery
    step(1, 1, 3'd3, 32'h0000_0003, 0, 0, 0);
    step(1, 1, 3'd3, 32'h0000_0000, 0, 0, 0);
    step(1, 1, 3'd1, 32'h1234_5678, 0, 0, 0);
    step(1, 1, 3'd4, 32'h0000_000F, 0, 0, 0);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_sel = 3'd3; in_handler = 0; fp_exec = 0;
    #1;
    chk("R5 control unchanged", rd_data, 32'h3);
    chk("R7 still unprivileged", {{(DATA_W-1){1'b0}}, privileged}, '0);
    rd(3'd4, 0); rd(3'd1, 0);
    rd(3'd1, 1);
    step(1, 1, 3'd3, 32'h0000_0000, 1, 0, 0);
    rd(3'd1, 0);

    // R9: mismatched fields, reserved code, privileged-only code
    step(1, 1, 3'd4, 32'h0000_000D, 0, 0, 0);
    step(0, 0, 0, '0, 0, 1, 1);
    step(1, 1, 3'd4, 32'h0000_000A, 0, 1, 1);
    step(0, 0, 0, '0, 0, 1, 1);
    step(1, 1, 3'd4, 32'h0000_0005, 0, 0, 0);
    step(0, 0, 0, '0, 0, 1, 0);
    step(0, 0, 0, '0, 0, 0, 0);

    // R10: allowed FP instruction sets the flag despite a same-cycle clear
    step(1, 1, 3'd3, 32'h0000_0000, 1, 1, 1);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_sel = 3'd3; in_handler = 1; fp_exec = 0;
    #1;
    chk("R10 context flag set", rd_data, 32'h4);
    m_fault = 1'b0;

    for (int n = 0; n < N_RANDOM; n++) begin
      logic [DATA_W-1:0] d;
      logic [2:0] s;
      s = 3'($urandom % 8);
      d = $urandom;
      if (s == 3'd4 && ($urandom % 2) == 0) d[3:2] = d[1:0];
      step(($urandom % 4) != 0, ($urandom % 2) == 0, s, d,
           ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule